// File: doc/BRIEF.md
# Mixed-Width Simple Dual-Port RAM

This block is a simple dual-port memory of 36,864 bits, organised as 4,096 byte lanes, each lane holding eight data bits and one parity bit. One port only writes and the other only reads. The write side is always a full word of eight lanes (64 data bits plus 8 parity bits). The read side has a width fixed at elaboration: 9, 18, 36 or 72 bits, that is one, two, four or eight lanes. Both addresses are 12-bit byte-lane addresses. Each port ignores the low address bits that fall inside its own word, so the write port drops three bits. A narrow read port drops only as many bits as its lane count covers.

Every word is carried on two pin groups. The low half uses the lo-side pins and covers lanes 0 to 3. The high half uses the hi-side pins and covers lanes 4 to 7. A narrow read comes out on the lo-side pins only. Reads are synchronous, with a single output register that holds its value while the read is idle. The output register has a synchronous reset. Parity bits are stored and returned unchanged; they are never generated or checked.

Top module: `mwsdp_ram`

## Requirements
- R1: When `wr_en` is high at a rising edge, the full eight-lane word is stored in entry `wr_addr[11:3]`. Bits `wr_addr[2:0]` have no effect on where it lands.
- R2: The stored word takes lanes 0-3 from `lo_wdata`/`lo_wpar` and lanes 4-7 from `hi_wdata`/`hi_wpar`. Lane j is data bits [8j+7:8j] with parity bit j.
- R3: With the default 18-bit read width, a read returns two lanes, 2k and 2k+1, of entry `rd_addr[11:3]`, where k = `rd_addr[2:1]`. The lower lane of the pair is the lower byte on the pins.
- R4: With the 18-bit read width, `rd_addr[0]` has no effect on the returned data.
- R5: When `rd_en` is high at a rising edge, the selected data appears on the read pins after that edge and not before it.
- R6: While `rd_en` is low, the read pins hold their last value whatever `rd_addr` does.
- R7: With `rst_n` low at a rising edge, every read pin becomes zero. Reset leaves the stored words intact.
- R8: A read and a write of the same entry in the same cycle return the contents from before the write. The next read returns the new word.
- R9: In a narrow read mode, the result sits in the low bits of `lo_rdata`/`lo_rpar`. The unused upper bits and all hi-side read pins are zero.
- R10: In the 72-bit read mode, a read returns the whole entry `rd_addr[11:3]`: lanes 0-3 on `lo_rdata`/`lo_rpar` and lanes 4-7 on `hi_rdata`/`hi_rpar`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset of the read register |
| rd_en | input | 1 | Read enable |
| rd_addr | input | 12 | Byte-lane read address |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 12 | Byte-lane write address |
| lo_wdata | input | 32 | Write data, lanes 0-3 |
| lo_wpar | input | 4 | Write parity, lanes 0-3 |
| hi_wdata | input | 32 | Write data, lanes 4-7 |
| hi_wpar | input | 4 | Write parity, lanes 4-7 |
| lo_rdata | output | 32 | Read data, low pin group |
| lo_rpar | output | 4 | Read parity, low pin group |
| hi_rdata | output | 32 | Read data, high pin group (72-bit mode only) |
| hi_rpar | output | 4 | Read parity, high pin group (72-bit mode only) |

## Verification
A read and a write can both target the same entry in one cycle. The bench provokes this by raising both enables on one edge, after seeding that entry with a known word. The read must return the older word, and a follow-up read of the same entry must return the newer one. A second instance in 72-bit mode shares every input with the default one, so each write is judged through both slice selection and the two-group pin split.

// File: rtl/mwsdp_pkg.sv
`timescale 1ns/1ps
// Shared constants and the stored word type for the mixed-width RAM.
// Assumes a lane is one data byte plus one parity bit, eight lanes per word.
package mwsdp_pkg;
    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned WORD_LANES = 8;
    localparam int unsigned HALF_LANES = WORD_LANES / 2;
    localparam int unsigned LANE_SEL_W = $clog2(WORD_LANES);

    typedef struct packed {
        logic [WORD_LANES*BYTE_W-1:0] data;
        logic [WORD_LANES-1:0]        par;
    } word_t;
endpackage

// File: rtl/mwsdp_store.sv
`timescale 1ns/1ps
// Word-wide storage array: one write port, one combinational read port.
// Assumes the caller registers the read result; there is no reset on the contents.
module mwsdp_store
    import mwsdp_pkg::*;
#(
    parameter int unsigned ENTRY_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ENTRY_W-1:0] wr_idx,
    input  word_t              wr_word,
    input  logic [ENTRY_W-1:0] rd_idx,
    output word_t              rd_word
);
    localparam int unsigned DEPTH = 1 << ENTRY_W;

    word_t mem [DEPTH];

    // Store a whole word at the write entry on an enabled edge.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_idx] <= wr_word;
        end
    end

    // Present the addressed entry; pre-edge contents give old-data on collision.
    assign rd_word = mem[rd_idx];

    // R1: an enabled write leaves the given word in the addressed entry.
    p_write_lands_r1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem[$past(wr_idx)] == $past(wr_word)));
endmodule

// File: rtl/mwsdp_lane_pick.sv
`timescale 1ns/1ps
// Picks the read-width slice of a stored word by lane group index.
// Assumes RD_LANES divides WORD_LANES; with a full-width read the index is unused.
module mwsdp_lane_pick
    import mwsdp_pkg::*;
#(
    parameter int unsigned RD_LANES = 2,
    parameter int unsigned SEL_W    = 2
) (
    input  word_t                       word,
    input  logic [SEL_W-1:0]            sel,
    output logic [RD_LANES*BYTE_W-1:0]  pk_data,
    output logic [RD_LANES-1:0]         pk_par
);
    localparam int unsigned SLICE_W = RD_LANES * BYTE_W;

    generate
        if (RD_LANES == WORD_LANES) begin : g_full
            logic unused_sel;
            assign unused_sel = ^sel;
            // Full-width read passes the whole word through.
            assign pk_data = word.data;
            assign pk_par  = word.par;
        end else begin : g_slice
            // Select lane group sel; group 0 is the least significant lanes.
            always_comb begin
                pk_data = word.data[int'(sel)*SLICE_W +: SLICE_W];
                pk_par  = word.par[int'(sel)*RD_LANES +: RD_LANES];
            end
        end
    endgenerate
endmodule

// File: rtl/mwsdp_ram.sv
`timescale 1ns/1ps
// Mixed-width simple dual-port RAM: eight-lane write, 1/2/4/8-lane read.
// Assumes RD_WIDTH is 9, 18, 36 or 72 and the byte-lane addresses are ADDR_W bits wide.
module mwsdp_ram
    import mwsdp_pkg::*;
#(
    parameter int unsigned RD_WIDTH = 18,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            rd_addr,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            wr_addr,
    input  logic [HALF_LANES*BYTE_W-1:0] lo_wdata,
    input  logic [HALF_LANES-1:0]        lo_wpar,
    input  logic [HALF_LANES*BYTE_W-1:0] hi_wdata,
    input  logic [HALF_LANES-1:0]        hi_wpar,
    output logic [HALF_LANES*BYTE_W-1:0] lo_rdata,
    output logic [HALF_LANES-1:0]        lo_rpar,
    output logic [HALF_LANES*BYTE_W-1:0] hi_rdata,
    output logic [HALF_LANES-1:0]        hi_rpar
);
    localparam int unsigned RD_LANES = RD_WIDTH / (BYTE_W + 1);
    localparam int unsigned ENTRY_W  = ADDR_W - LANE_SEL_W;
    localparam int unsigned DROP_W   = $clog2(RD_LANES);
    localparam int unsigned SEL_RAW  = LANE_SEL_W - DROP_W;
    localparam int unsigned SEL_W    = (SEL_RAW > 0) ? SEL_RAW : 1;
    localparam int unsigned SLICE_W  = RD_LANES * BYTE_W;

    word_t                wr_word;
    word_t                rd_word;
    logic [SEL_W-1:0]     lane_sel;
    logic [SLICE_W-1:0]   pk_data;
    logic [RD_LANES-1:0]  pk_par;
    logic [SLICE_W-1:0]   q_data;
    logic [RD_LANES-1:0]  q_par;
    logic                 unused_addr;

    // Assemble the stored word: lo-side pins are lanes 0-3, hi-side lanes 4-7.
    assign wr_word.data = {hi_wdata, lo_wdata};
    assign wr_word.par  = {hi_wpar, lo_wpar};
    assign unused_addr  = ^{rd_addr, wr_addr};

    mwsdp_store #(
        .ENTRY_W (ENTRY_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_addr[ADDR_W-1:LANE_SEL_W]),
        .wr_word (wr_word),
        .rd_idx  (rd_addr[ADDR_W-1:LANE_SEL_W]),
        .rd_word (rd_word)
    );

    generate
        if (RD_LANES == WORD_LANES) begin : g_sel_wide
            // No lane group to choose at full width.
            assign lane_sel = '0;
        end else begin : g_sel_narrow
            // Lane group comes from the in-word address bits above the dropped ones.
            assign lane_sel = rd_addr[LANE_SEL_W-1 -: SEL_W];
        end
    endgenerate

    mwsdp_lane_pick #(
        .RD_LANES (RD_LANES),
        .SEL_W    (SEL_W)
    ) u_pick (
        .word    (rd_word),
        .sel     (lane_sel),
        .pk_data (pk_data),
        .pk_par  (pk_par)
    );

    // Output register: clear on reset, load on read enable, otherwise hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_data <= '0;
            q_par  <= '0;
        end else if (rd_en) begin
            q_data <= pk_data;
            q_par  <= pk_par;
        end
    end

    generate
        if (RD_LANES == WORD_LANES) begin : g_pins_wide
            // Full word split across both pin groups.
            assign lo_rdata = q_data[HALF_LANES*BYTE_W-1:0];
            assign hi_rdata = q_data[WORD_LANES*BYTE_W-1:HALF_LANES*BYTE_W];
            assign lo_rpar  = q_par[HALF_LANES-1:0];
            assign hi_rpar  = q_par[WORD_LANES-1:HALF_LANES];
        end else begin : g_pins_narrow
            // Narrow result on the lo-side pins, everything else zero.
            always_comb begin
                lo_rdata                = '0;
                lo_rpar                 = '0;
                lo_rdata[SLICE_W-1:0]   = q_data;
                lo_rpar[RD_LANES-1:0]   = q_par;
            end
            assign hi_rdata = '0;
            assign hi_rpar  = '0;
        end
    endgenerate

    // R5: an enabled read shows the picked slice on the pins after the edge.
    p_read_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> ({hi_rdata, lo_rdata} == 64'($past(pk_data)))
               && ({hi_rpar, lo_rpar} == 8'($past(pk_par))));

    // R6: with the read idle the pins do not move.
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable({hi_rdata, lo_rdata, hi_rpar, lo_rpar}));

    // R7: a reset edge leaves every read pin at zero.
    p_reset_clear_r7: assert property (@(posedge clk)
        !rst_n |=> ({hi_rdata, lo_rdata, hi_rpar, lo_rpar} == '0));
endmodule

// File: tb/test_mwsdp_ram.sv
`timescale 1ns/1ps
// Directed bench: an 18-bit read instance and a 72-bit read instance share all inputs.
module test_mwsdp_ram;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] lo_wdata = '0;
    logic [3:0]  lo_wpar = '0;
    logic [31:0] hi_wdata = '0;
    logic [3:0]  hi_wpar = '0;
    logic [31:0] n_lo_d, n_hi_d, w_lo_d, w_hi_d;
    logic [3:0]  n_lo_p, n_hi_p, w_lo_p, w_hi_p;
    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mwsdp_ram #(.RD_WIDTH(18)) i_mwsdp_ram (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .lo_wdata(lo_wdata), .lo_wpar(lo_wpar),
        .hi_wdata(hi_wdata), .hi_wpar(hi_wpar), .lo_rdata(n_lo_d), .lo_rpar(n_lo_p),
        .hi_rdata(n_hi_d), .hi_rpar(n_hi_p));

    mwsdp_ram #(.RD_WIDTH(72)) i_mwsdp_ram_wide (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .lo_wdata(lo_wdata), .lo_wpar(lo_wpar),
        .hi_wdata(hi_wdata), .hi_wpar(hi_wpar), .lo_rdata(w_lo_d), .lo_rpar(w_lo_p),
        .hi_rdata(w_hi_d), .hi_rpar(w_hi_p));

    function automatic logic [63:0] pat_data(int e);
        logic [63:0] d;
        for (int j = 0; j < 8; j++) d[j*8 +: 8] = 8'(e*13 + j*29 + 7);
        return d;
    endfunction

    function automatic logic [7:0] pat_par(int e);
        return 8'(e*53 + 17);
    endfunction

    task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    // Compare the 18-bit instance against lanes 2k,2k+1 of a pattern.
    task automatic check_narrow(string tag, int e, int k);
        check({tag, " data"}, {n_hi_d, n_lo_d}, (pat_data(e) >> (16*k)) & 64'hFFFF);
        check({tag, " par"}, 64'({n_hi_p, n_lo_p}), 64'((pat_par(e) >> (2*k)) & 8'h3));
    endtask

    task automatic check_wide(string tag, int e);
        check({tag, " data"}, {w_hi_d, w_lo_d}, pat_data(e));
        check({tag, " par"}, 64'({w_hi_p, w_lo_p}), 64'(pat_par(e)));
    endtask

    task automatic write_word(int e, int low, int p);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'(e*8 + low);
        {hi_wdata, lo_wdata} = pat_data(p);
        {hi_wpar, lo_wpar}   = pat_par(p);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic read_at(int a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 12'(a);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R7 reset narrow", {n_hi_d, n_lo_d, 8'(n_hi_p), 8'(n_lo_p)} , '0);
        check("R7 reset wide", {w_hi_d, w_lo_d}, '0);
        check("R7 reset wide par", 64'({w_hi_p, w_lo_p}), '0);
        rst_n = 1'b1;
    endtask

    task automatic t_fill;
        write_word(5, 3, 5);      // R1: low write address bits ignored
        write_word(9, 0, 9);
        write_word(100, 7, 100);
    endtask

    task automatic t_narrow_slices;
        for (int k = 0; k < 4; k++) begin
            read_at(5*8 + 2*k);
            check_narrow("R3 slice", 5, k);
        end
        check("R9 hi pins quiet", {n_hi_d, 28'(0), n_hi_p}, '0);
    endtask

    task automatic t_ignored_bit;
        read_at(5*8 + 5);
        check_narrow("R4 addr bit0 ignored", 5, 2);
    endtask

    task automatic t_wide;
        read_at(5*8 + 6);
        check_wide("R10 R2 wide split", 5);
        check_narrow("R3 shared read", 5, 3);
        read_at(100*8 + 1);
        check_wide("R1 entry from wr_addr[11:3]", 100);
    endtask

    task automatic t_latency;
        read_at(5*8 + 6);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 12'(100*8);
        #1;
        check_narrow("R5 before edge", 5, 3);
        @(negedge clk);
        rd_en = 1'b0;
        check_narrow("R5 after edge", 100, 0);
    endtask

    task automatic t_hold;
        rd_addr = 12'(9*8 + 2);
        repeat (3) @(negedge clk);
        check_narrow("R6 hold narrow", 100, 0);
        check_wide("R6 hold wide", 100);
    endtask

    task automatic t_collide;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 12'(9*8);
        wr_en = 1'b1; wr_addr = 12'(9*8 + 4);
        {hi_wdata, lo_wdata} = pat_data(309);
        {hi_wpar, lo_wpar}   = pat_par(309);
        @(negedge clk);
        rd_en = 1'b0; wr_en = 1'b0;
        check_narrow("R8 old data narrow", 9, 0);
        check_wide("R8 old data wide", 9);
        read_at(9*8);
        check_narrow("R8 new data narrow", 309, 0);
        check_wide("R8 new data wide", 309);
    endtask

    task automatic t_reset_mid;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R7 mid reset narrow", {n_hi_d, n_lo_d}, '0);
        check("R7 mid reset wide", {w_hi_d, w_lo_d}, '0);
        read_at(100*8 + 6);
        check_narrow("R7 contents kept", 100, 3);
        check_wide("R7 contents kept", 100);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got timeout exp finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_fill();
        t_narrow_slices();
        t_ignored_bit();
        t_wide();
        t_latency();
        t_hold();
        t_collide();
        t_reset_mid();
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule